// File: doc/BRIEF.md
# Direction-Configurable Four-Pin GPIO Port

This block is a small general-purpose I/O port with four pins. Pins 0 to 2 each have an output data latch and a direction latch, and both are written over a simple single-cycle register bus. Pin 3 can only be an input. A direction bit of 1 makes its pin an input. A direction bit of 0 makes the pin drive the value held in its data latch. Pins are modelled as a tri-state output (`pin_out` with `pin_oe`) plus a separate input, and the input is passed through a two-stage synchronizer before it can be read.

A 4-bit analog-configuration input selects which of pins 0 to 2 are in analog mode. A pin in analog mode reads as 0 through the data register, but its direction bit still controls its driver. The control register also holds the direction bits, a mode-enable bit for an external parallel slave interface, two read-only status flags from that interface, and a sticky overflow flag. When the slave mode is enabled, pins 0 to 2 stop driving so that they can serve as control inputs.

Top module: `qport_gpio`

## Requirements
- R1: While reset is held, the control register (bus_addr=1) reads 0x0F: direction bits 2:0 are 1, bit 3 is 1, and bits 7:4 are 0. During reset pin_oe is 000 and slv_mode is 0.
- R2: A control write loads wdata[2:0] into the direction latches on the next clock edge. With slave mode off, pin_oe[k] is 1 exactly when direction bit k is 0.
- R3: Control register bit 3 always reads 1, whatever value is written to it.
- R4: A data-register write (bus_addr=0) loads wdata[2:0] into the output latches even when the pins are inputs. pin_out shows the latched value from the next clock edge on, including after the pin is later switched to output.
- R5: A data-register read returns the pin levels {pin_in[3:0]} delayed by two clock edges, in bits 3:0, with bits 7:4 read as 0.
- R6: A pin in analog mode reads as 0 in the data register, while its driver still follows its direction bit. Pin 3 is never masked.
- R7: Analog decode: pin k (0..2) is analog when ana_cfg < 15-k. So code 15 makes all pins digital, 14 makes pin 0 analog, 13 makes pins 0 and 1 analog, and codes 12 and below make pins 0 to 2 analog.
- R8: Control bit 4 is the slave-mode enable. It is readable and writable and appears on slv_mode. While it is 1, pin_oe is 000.
- R9: Control bits 7 and 6 read slv_in_full and slv_out_full directly. Writes to these bits have no effect.
- R10: Control bit 5 is a sticky overflow flag. A slv_ovf_set pulse sets it. A control write with bit 5 equal to 0 clears it, and a write with bit 5 equal to 1 leaves it unchanged. If a set and a clear arrive in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_we | input | 1 | Register write strobe, one cycle per write |
| bus_addr | input | 1 | Register select: 0 = data, 1 = control |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for the register selected by bus_addr |
| ana_cfg | input | 4 | Analog-mode configuration code |
| pin_in | input | 4 | Pin input levels (asynchronous) |
| pin_out | output | 3 | Output latch values for pins 2:0 |
| pin_oe | output | 3 | Output enables for pins 2:0 |
| slv_in_full | input | 1 | Slave interface input-full status |
| slv_out_full | input | 1 | Slave interface output-full status |
| slv_ovf_set | input | 1 | One-cycle pulse that sets the overflow flag |
| slv_mode | output | 1 | Slave-mode enable to the parallel slave interface |

## Verification
The assertions assume that bus_we is a clean synchronous strobe whose address and data are stable around the sampling edge. They also assume that slv_ovf_set is synchronous to clk, while pin_in may change at any time because it goes through the synchronizer. The stimulus changes every input only on the falling edge and holds it for at least one full cycle. It waits two rising edges after any pin change before it reads the pins, and it keeps ana_cfg steady while a read is being compared. All checks on pin levels are taken through the data register after the synchronizer latency. Tests of ignored writes are followed by a read-back of the control register.

// File: rtl/qport_pkg.sv
package qport_pkg;
  localparam logic ADDR_DATA = 1'b0;
  localparam logic ADDR_CTRL = 1'b1;

  localparam int CTRL_FIXED_ONE = 3;
  localparam int CTRL_MODE      = 4;
  localparam int CTRL_OVF       = 5;
  localparam int CTRL_OUT_FULL  = 6;
  localparam int CTRL_IN_FULL   = 7;
endpackage

// File: rtl/qport_rst_sync.sv
module qport_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] stg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= 2'b00;
    else        stg_q <= {stg_q[0], 1'b1};
  end

  assign rst_n_sync = stg_q[1];
endmodule

// File: rtl/qport_sync.sv
module qport_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [W-1:0] stg_d;
    if (s == 0) begin : g_first
      assign stg_d = d;
    end else begin : g_next
      assign stg_d = stg_q[s-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg_q[s] <= '0;
      else        stg_q[s] <= stg_d;
    end
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/qport_ana_decode.sv
module qport_ana_decode #(
  parameter int IO_PINS = 3,
  parameter int CFG_W   = 4
) (
  input  logic [CFG_W-1:0]   cfg,
  output logic [IO_PINS-1:0] ana_mask
);
  localparam int CFG_TOP = (1 << CFG_W) - 1;

  for (genvar k = 0; k < IO_PINS; k++) begin : g_pin
    localparam int LIMIT = CFG_TOP - k;
    assign ana_mask[k] = (int'(cfg) < LIMIT);
  end

  always_comb begin
    for (int k = 1; k < IO_PINS; k++) begin
      // R7: analog pins always form a contiguous run from pin 0 upward
      assert_ana_contiguous_R7: assert (!ana_mask[k] || ana_mask[k-1]);
    end
  end
endmodule

// File: rtl/qport_ctrl_reg.sv
module qport_ctrl_reg
  import qport_pkg::*;
#(
  parameter int IO_PINS = 3,
  parameter int DATA_W  = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [DATA_W-1:0]  wdata,
  input  logic               in_full,
  input  logic               out_full,
  input  logic               ovf_set,
  output logic [IO_PINS-1:0] dir,
  output logic               mode,
  output logic [DATA_W-1:0]  rdata
);
  logic [IO_PINS-1:0] dir_q, dir_d;
  logic               mode_q, mode_d;
  logic               ovf_q, ovf_d;
  logic               ovf_clr;

  always_comb begin
    dir_d   = dir_q;
    mode_d  = mode_q;
    ovf_clr = wr_en && !wdata[CTRL_OVF];
    if (wr_en) begin
      dir_d  = wdata[IO_PINS-1:0];
      mode_d = wdata[CTRL_MODE];
    end
    ovf_d = ovf_set || (ovf_q && !ovf_clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= '1;
      mode_q <= 1'b0;
      ovf_q  <= 1'b0;
    end else begin
      dir_q  <= dir_d;
      mode_q <= mode_d;
      ovf_q  <= ovf_d;
    end
  end

  always_comb begin
    rdata                 = '0;
    rdata[IO_PINS-1:0]    = dir_q;
    rdata[CTRL_FIXED_ONE] = 1'b1;
    rdata[CTRL_MODE]      = mode_q;
    rdata[CTRL_OVF]       = ovf_q;
    rdata[CTRL_OUT_FULL]  = out_full;
    rdata[CTRL_IN_FULL]   = in_full;
  end

  assign dir  = dir_q;
  assign mode = mode_q;

  assert_dir_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> dir_q == $past(wdata[IO_PINS-1:0]));

  assert_ovf_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_set |=> ovf_q);

  assert_ovf_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_q && !(wr_en && !wdata[CTRL_OVF])) |=> ovf_q);
endmodule

// File: rtl/qport_gpio.sv
module qport_gpio
  import qport_pkg::*;
#(
  parameter int PINS        = 4,
  parameter int DATA_W      = 8,
  parameter int CFG_W       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic              bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [CFG_W-1:0]  ana_cfg,
  input  logic [PINS-1:0]   pin_in,
  output logic [PINS-2:0]   pin_out,
  output logic [PINS-2:0]   pin_oe,
  input  logic              slv_in_full,
  input  logic              slv_out_full,
  input  logic              slv_ovf_set,
  output logic              slv_mode
);
  localparam int IO_PINS = PINS - 1;

  logic               rst_n_s;
  logic [PINS-1:0]    pin_sync;
  logic [IO_PINS-1:0] ana_mask;
  logic [IO_PINS-1:0] dir;
  logic               mode;
  logic [DATA_W-1:0]  ctrl_rdata;
  logic [IO_PINS-1:0] lat_q;
  logic               data_we, ctrl_we;

  assign data_we = bus_we && (bus_addr == ADDR_DATA);
  assign ctrl_we = bus_we && (bus_addr == ADDR_CTRL);

  qport_rst_sync i_rst (.clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_s));

  qport_sync #(.W(PINS), .STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .rst_n(rst_n_s), .d(pin_in), .q(pin_sync));

  qport_ana_decode #(.IO_PINS(IO_PINS), .CFG_W(CFG_W)) i_ana (
    .cfg(ana_cfg), .ana_mask(ana_mask));

  qport_ctrl_reg #(.IO_PINS(IO_PINS), .DATA_W(DATA_W)) i_ctrl (
    .clk(clk), .rst_n(rst_n_s), .wr_en(ctrl_we), .wdata(bus_wdata),
    .in_full(slv_in_full), .out_full(slv_out_full), .ovf_set(slv_ovf_set),
    .dir(dir), .mode(mode), .rdata(ctrl_rdata));

  // output latches carry no reset; they only matter once written
  always_ff @(posedge clk) begin
    if (data_we) lat_q <= bus_wdata[IO_PINS-1:0];
  end

  assign pin_out  = lat_q;
  assign pin_oe   = mode ? '0 : ~dir;
  assign slv_mode = mode;

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == ADDR_CTRL) begin
      bus_rdata = ctrl_rdata;
    end else begin
      bus_rdata[IO_PINS-1:0] = pin_sync[IO_PINS-1:0] & ~ana_mask;
      bus_rdata[PINS-1]      = pin_sync[PINS-1];
    end
  end

  assert_latch_write_R4: assert property (@(posedge clk) disable iff (!rst_n_s)
    data_we |=> pin_out == $past(bus_wdata[IO_PINS-1:0]));

  assert_slave_no_drive_R8: assert property (@(posedge clk) disable iff (!rst_n_s)
    (ctrl_we && bus_wdata[CTRL_MODE]) |=> (pin_oe == '0 && slv_mode));

  assert_out_drive_R2: assert property (@(posedge clk) disable iff (!rst_n_s)
    (ctrl_we && !bus_wdata[CTRL_MODE]) |=> pin_oe == ~$past(bus_wdata[IO_PINS-1:0]));
endmodule

// File: tb/test_qport_gpio.sv
module test_qport_gpio;
  localparam time CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       bus_we;
  logic       bus_addr;
  logic [7:0] bus_wdata;
  logic [7:0] bus_rdata;
  logic [3:0] ana_cfg;
  logic [3:0] pin_in;
  logic [2:0] pin_out, pin_oe;
  logic       slv_in_full, slv_out_full, slv_ovf_set, slv_mode;

  always #(CLK_PERIOD/2) clk = ~clk;

  qport_gpio i_qport_gpio (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ana_cfg(ana_cfg),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
    .slv_in_full(slv_in_full), .slv_out_full(slv_out_full),
    .slv_ovf_set(slv_ovf_set), .slv_mode(slv_mode));

  typedef enum int {S_RDATA, S_OE, S_OUT, S_MODE} sel_e;
  typedef struct {
    sel_e       sel;
    logic [7:0] exp;
    string      req;
  } item_t;

  item_t sb_q[$];
  int    n_chk  = 0;
  int    n_fail = 0;
  bit    done   = 0;

  // monitor: pops queued expectations and compares against the outputs
  initial begin
    forever begin
      wait (sb_q.size() > 0);
      #1;
      begin
        item_t it;
        logic [7:0] act;
        it = sb_q.pop_front();
        case (it.sel)
          S_RDATA: act = bus_rdata;
          S_OE:    act = {5'b0, pin_oe};
          S_OUT:   act = {5'b0, pin_out};
          default: act = {7'b0, slv_mode};
        endcase
        n_chk++;
        if (act !== it.exp) begin
          n_fail++;
          $display("FAIL %s sel=%0d actual=%02h expected=%02h", it.req, it.sel, act, it.exp);
        end
      end
    end
  end

  task automatic push(sel_e s, logic [7:0] e, string r);
    item_t it;
    it.sel = s; it.exp = e; it.req = r;
    sb_q.push_back(it);
  endtask

  task automatic rd_expect(logic a, logic [7:0] e, string r);
    @(negedge clk);
    bus_addr = a;
    push(S_RDATA, e, r);
  endtask

  task automatic wr(logic a, logic [7:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic set_pins(logic [3:0] v);
    @(negedge clk);
    pin_in = v;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL all-requirements watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bus_we = 1'b0; bus_addr = 1'b1; bus_wdata = '0;
    ana_cfg = 4'd0; pin_in = 4'b0;
    slv_in_full = 1'b0; slv_out_full = 1'b0; slv_ovf_set = 1'b0;
    repeat (3) @(negedge clk);
    rd_expect(1'b1, 8'h0F, "R1 ctrl reset");
    push(S_OE, 8'h00, "R1 oe reset");
    push(S_MODE, 8'h00, "R1 mode reset");
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R2, R3
    wr(1'b1, 8'h00);
    rd_expect(1'b1, 8'h08, "R3 bit3 reads one");
    push(S_OE, 8'h07, "R2 all outputs");
    wr(1'b1, 8'h02);
    push(S_OE, 8'h05, "R2 mixed direction");
    rd_expect(1'b1, 8'h0A, "R3 bit3 after write zero");

    // R4
    wr(1'b1, 8'h00);
    wr(1'b0, 8'h05);
    push(S_OUT, 8'h05, "R4 latch as output");
    wr(1'b1, 8'h07);
    push(S_OE, 8'h00, "R2 all inputs");
    wr(1'b0, 8'hFA);
    push(S_OUT, 8'h02, "R4 latch while input");
    wr(1'b1, 8'h00);
    push(S_OE, 8'h07, "R4 switch to output");
    push(S_OUT, 8'h02, "R4 latched value drives");

    // R5, R7, R6
    ana_cfg = 4'd15;
    set_pins(4'b1111);
    rd_expect(1'b0, 8'h0F, "R5 all high digital");
    @(negedge clk); ana_cfg = 4'd14; push(S_RDATA, 8'h0E, "R7 code 14");
    @(negedge clk); ana_cfg = 4'd13; push(S_RDATA, 8'h0C, "R7 code 13");
    @(negedge clk); ana_cfg = 4'd12; push(S_RDATA, 8'h08, "R7 code 12");
    @(negedge clk); ana_cfg = 4'd0;  push(S_RDATA, 8'h08, "R6 pin3 unmasked");
    push(S_OE, 8'h07, "R6 analog still drives");
    @(negedge clk); ana_cfg = 4'd15;
    set_pins(4'b0101);
    rd_expect(1'b0, 8'h05, "R5 pattern 0101");
    @(negedge clk); pin_in = 4'b1010;
    @(negedge clk); push(S_RDATA, 8'h05, "R5 one edge old value");
    @(negedge clk); push(S_RDATA, 8'h0A, "R5 two edges new value");

    // R8
    wr(1'b1, 8'h10);
    rd_expect(1'b1, 8'h18, "R8 mode readback");
    push(S_MODE, 8'h01, "R8 mode pin");
    push(S_OE, 8'h00, "R8 no drive");
    wr(1'b1, 8'h15);
    push(S_OE, 8'h00, "R8 no drive mixed dir");
    wr(1'b1, 8'h00);
    push(S_MODE, 8'h00, "R8 mode off");
    push(S_OE, 8'h07, "R8 drive restored");

    // R9
    @(negedge clk); slv_in_full = 1'b1;
    rd_expect(1'b1, 8'h88, "R9 in full");
    @(negedge clk); slv_out_full = 1'b1;
    push(S_RDATA, 8'hC8, "R9 both flags");
    wr(1'b1, 8'hC0);
    rd_expect(1'b1, 8'hC8, "R9 write ignored");
    @(negedge clk); slv_in_full = 1'b0; slv_out_full = 1'b0;
    push(S_RDATA, 8'h08, "R9 flags clear");

    // R10
    @(negedge clk); slv_ovf_set = 1'b1;
    @(negedge clk); slv_ovf_set = 1'b0;
    rd_expect(1'b1, 8'h28, "R10 set");
    wr(1'b1, 8'h20);
    rd_expect(1'b1, 8'h28, "R10 write one keeps");
    wr(1'b1, 8'h00);
    rd_expect(1'b1, 8'h08, "R10 write zero clears");
    @(negedge clk);
    bus_we = 1'b1; bus_addr = 1'b1; bus_wdata = 8'h00; slv_ovf_set = 1'b1;
    @(negedge clk);
    bus_we = 1'b0; slv_ovf_set = 1'b0;
    push(S_RDATA, 8'h28, "R10 set wins");
    wr(1'b1, 8'h00);
    rd_expect(1'b1, 8'h08, "R10 clear after");

    wait (sb_q.size() == 0);
    #3;
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule